// File: doc/BRIEF.md
# Parallel Flash Bus Cycle Front End

This block is the device-side bus interface of an asynchronous parallel flash memory, rebuilt as synchronous logic. A fast system clock oversamples the chip-select, write-strobe and output-enable pins, plus a bus reset pin. Each control pin passes through a two-flop synchronizer and a glitch filter. From the filtered levels the block classifies the bus as a read, a write, an output-disable or a standby cycle.

Reads are served from a four-word page buffer. A new page is fetched from a synchronous array only when the upper address bits leave the buffered page. Reads inside the buffered page come straight from the buffer, and the block flags each one as a page hit.

A write cycle captures the address when the second of the two strobes falls and captures the data when the first of them rises. The finished write leaves the block as a command on a valid/ready channel. That channel has no way to stall the bus. While a command is waiting, it holds steady until it is accepted, and any write that completes in the meantime is discarded. An idle timer raises an automatic-standby flag once the bus has been quiet for a set number of cycles.

Top module: `flash_bus_fe`

## Requirements
- R1: `dq_oe` is high only while the filtered levels show chip select low, output enable low, write strobe high and bus reset high. Whenever `page_hit` is high, `dq_out` carries the word at `addr`.
- R2: The page buffer holds 4 words, and `addr[1:0]` selects the word within the page. When a read asks for `addr[AW-1:2]` different from the buffered page, the block raises `mem_rd_en` for one fetch with `mem_rd_addr = addr[AW-1:2]`. The buffer loads from `mem_rd_data` one cycle later, with word i in bits `[i*DW +: DW]`. A read within the buffered page raises `page_hit` in the same cycle and issues no fetch.
- R3: The command address is the value on `addr` at the moment the later of the two strobes (chip select, write strobe) falls, after filtering.
- R4: The command data is the value on `dq_in` at the moment the earlier of the two strobes rises, after filtering.
- R5: A write cycle during which output enable is seen low produces no command.
- R6: `cmd_valid`, `cmd_addr` and `cmd_data` stay unchanged while `cmd_valid` is high and `cmd_ready` is low. A write that completes while a command is still pending and not accepted is discarded.
- R7: A level on chip select, write strobe, output enable or bus reset that lasts fewer than `GLITCH_CYC` clock cycles has no effect. A level that lasts `GLITCH_CYC` cycles or more is taken.
- R8: `auto_stby` rises after `IDLE_CYC` cycles with no change on the filtered control pins or on `addr`, and it falls on the cycle after any such change. An ongoing read keeps `dq_oe` high and its data driven while `auto_stby` is high.
- R9: `stby` follows the filtered chip-select level (high = standby). With chip select high, or with output enable high, `dq_oe` is low.
- R10: While bus reset is low (filtered), the block drives no data, fetches nothing and accepts no write, and it invalidates the page buffer. The first read after release therefore fetches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low system reset |
| ce_n | input | 1 | Chip select pin, active low |
| we_n | input | 1 | Write strobe pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| bus_rst_n | input | 1 | Bus reset pin, active low |
| addr | input | AW | Word address pins |
| dq_in | input | DW | Data pins, inbound |
| dq_out | output | DW | Data pins, outbound |
| dq_oe | output | 1 | Drive enable for the data pins |
| stby | output | 1 | Standby (chip not selected) |
| auto_stby | output | 1 | Bus idle for IDLE_CYC cycles |
| page_hit | output | 1 | Read served from the buffered page |
| mem_rd_en | output | 1 | Page fetch request to the array |
| mem_rd_addr | output | AW-2 | Page address of the fetch |
| mem_rd_data | input | 4*DW | Page returned one cycle after the request |
| cmd_valid | output | 1 | Write command available |
| cmd_ready | input | 1 | Command interface accepts |
| cmd_addr | output | AW | Latched write address |
| cmd_data | output | DW | Latched write data |

## Verification
A completing write and a waiting command can fall in the same cycle. The bench provokes this by holding `cmd_ready` low and running a second full write cycle. It then judges that the first address and data are still presented and that only one command is counted after `cmd_ready` rises. Automatic standby and an active read also overlap. The bench holds a read steady past the idle limit and checks that the flag rises while `dq_oe` and the addressed word stay on the pins.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int PAGE_WORDS = 4;
  localparam int PW         = $clog2(PAGE_WORDS);
  localparam int NPIN       = 4;
  typedef enum int {PIN_CE = 0, PIN_WE = 1, PIN_OE = 2, PIN_RST = 3} pin_e;
endpackage

// File: rtl/flash_fe_deglitch.sv
module flash_fe_deglitch #(
  parameter int CYC     = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic synced,
  output logic filt
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic          s1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1     <= RST_VAL;
      synced <= RST_VAL;
      filt   <= RST_VAL;
      cnt    <= '0;
    end else begin
      s1     <= pin;
      synced <= s1;
      if (synced != filt) begin
        if (cnt == CW'(CYC - 1)) begin
          filt <= synced;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/flash_fe_wrcap.sv
module flash_fe_wrcap #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          we_f,
  input  logic          oe_f,
  input  logic          bus_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  input  logic          cmd_ready,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  logic          active, act_q, spoiled;
  logic [AW-1:0] a_lat;

  assign active = !ce_f && !we_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      spoiled   <= 1'b0;
      a_lat     <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      act_q <= active;
      if (active) begin
        if (!act_q) a_lat <= addr;
        spoiled <= (act_q && spoiled) || !oe_f || !bus_en;
      end
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      if (act_q && !active && !spoiled && oe_f && bus_en &&
          (!cmd_valid || cmd_ready)) begin
        cmd_valid <= 1'b1;
        cmd_addr  <= a_lat;
        cmd_data  <= dq_in;
      end
    end
  end
endmodule

// File: rtl/flash_fe_page.sv
module flash_fe_page
  import flash_fe_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_cycle,
  input  logic                     bus_en,
  input  logic [AW-1:0]            addr,
  input  logic [PAGE_WORDS*DW-1:0] mem_rd_data,
  output logic                     mem_rd_en,
  output logic [AW-PW-1:0]         mem_rd_addr,
  output logic [DW-1:0]            dq_out,
  output logic                     page_hit
);
  localparam int TW = AW - PW;

  logic [PAGE_WORDS-1:0][DW-1:0] words;
  logic [TW-1:0]                 tag, fetch_tag;
  logic                          pg_valid, fetch_pend;

  assign page_hit    = rd_cycle && pg_valid && (tag == addr[AW-1:PW]);
  assign mem_rd_en   = rd_cycle && bus_en && !page_hit && !fetch_pend;
  assign mem_rd_addr = addr[AW-1:PW];
  assign dq_out      = page_hit ? words[addr[PW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_valid   <= 1'b0;
      fetch_pend <= 1'b0;
      tag        <= '0;
      fetch_tag  <= '0;
      words      <= '0;
    end else begin
      fetch_pend <= mem_rd_en;
      if (mem_rd_en) fetch_tag <= addr[AW-1:PW];
      if (!bus_en) begin
        pg_valid <= 1'b0;
      end else if (fetch_pend) begin
        words    <= mem_rd_data;
        tag      <= fetch_tag;
        pg_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_bus_fe.sv
module flash_bus_fe
  import flash_fe_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int GLITCH_CYC = 2,
  parameter int IDLE_CYC   = 75
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_n,
  input  logic                     we_n,
  input  logic                     oe_n,
  input  logic                     bus_rst_n,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            dq_in,
  output logic [DW-1:0]            dq_out,
  output logic                     dq_oe,
  output logic                     stby,
  output logic                     auto_stby,
  output logic                     page_hit,
  output logic                     mem_rd_en,
  output logic [AW-PW-1:0]         mem_rd_addr,
  input  logic [PAGE_WORDS*DW-1:0] mem_rd_data,
  output logic                     cmd_valid,
  input  logic                     cmd_ready,
  output logic [AW-1:0]            cmd_addr,
  output logic [DW-1:0]            cmd_data
);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [NPIN-1:0] pin_raw, pin_s, pin_f, pin_q;
  logic            ce_f, we_f, oe_f, bus_en, rd_cycle, activity;
  logic [AW-1:0]   addr_q;
  logic [IW-1:0]   idle_cnt;

  assign pin_raw = {bus_rst_n, oe_n, we_n, ce_n};

  for (genvar g = 0; g < NPIN; g++) begin : g_filt
    flash_fe_deglitch #(.CYC(GLITCH_CYC), .RST_VAL(1'b1)) u_dg (
      .clk(clk), .rst_n(rst_n), .pin(pin_raw[g]),
      .synced(pin_s[g]), .filt(pin_f[g])
    );
  end

  assign ce_f     = pin_f[PIN_CE];
  assign we_f     = pin_f[PIN_WE];
  assign oe_f     = pin_f[PIN_OE];
  assign bus_en   = pin_f[PIN_RST];
  assign rd_cycle = !ce_f && !oe_f && we_f && bus_en;
  assign dq_oe    = rd_cycle;
  assign stby     = ce_f;

  flash_fe_page #(.AW(AW), .DW(DW)) u_page (
    .clk(clk), .rst_n(rst_n), .rd_cycle(rd_cycle), .bus_en(bus_en),
    .addr(addr), .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .dq_out(dq_out), .page_hit(page_hit)
  );

  flash_fe_wrcap #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .ce_f(ce_f), .we_f(we_f), .oe_f(oe_f),
    .bus_en(bus_en), .addr(addr), .dq_in(dq_in), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  assign activity  = (pin_f != pin_q) || (addr != addr_q);
  assign auto_stby = (idle_cnt == IW'(IDLE_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q    <= '1;
      addr_q   <= '0;
      idle_cnt <= '0;
    end else begin
      pin_q  <= pin_f;
      addr_q <= addr;
      if (activity)       idle_cnt <= '0;
      else if (!auto_stby) idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/flash_bus_fe_chk.sv
module flash_bus_fe_chk
  import flash_fe_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] pin_s,
  input logic [NPIN-1:0] pin_f,
  input logic            bus_en,
  input logic            dq_oe,
  input logic            page_hit,
  input logic            stby,
  input logic            mem_rd_en,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [AW-1:0]   cmd_addr,
  input logic [DW-1:0]   cmd_data,
  input logic            activity,
  input logic            auto_stby
);
  a_r1_hit_drives: assert property (@(posedge clk) disable iff (!rst_n)
    page_hit |-> dq_oe);

  a_r2_no_fetch_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !page_hit);

  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));

  for (genvar g = 0; g < NPIN; g++) begin : g_r7
    a_r7_filter_src: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_f[g] != $past(pin_f[g])) |-> ($past(pin_s[g]) == pin_f[g]));
  end

  a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !auto_stby);

  a_r9_stby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    stby |-> !dq_oe);

  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> (!dq_oe && !mem_rd_en));
endmodule

bind flash_bus_fe flash_bus_fe_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .pin_f(pin_f), .bus_en(bus_en),
  .dq_oe(dq_oe), .page_hit(page_hit), .stby(stby), .mem_rd_en(mem_rd_en),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
  .cmd_data(cmd_data), .activity(activity), .auto_stby(auto_stby)
);

// File: tb/flash_bus_fe_tb_top.sv
module flash_bus_fe_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1, we_n = 1, oe_n = 1, bus_rst_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, stby, auto_stby, page_hit, mem_rd_en, cmd_valid;
  logic cmd_ready = 1'b1;
  logic [AW-3:0] mem_rd_addr;
  logic [4*DW-1:0] mem_rd_data = '0;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  int checks = 0, errors = 0, fetches = 0, cmds = 0, cyc = 0;
  bit done = 0, oe_seen = 0;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;

  always #2 clk = ~clk;

  flash_bus_fe #(.AW(AW), .DW(DW), .GLITCH_CYC(2), .IDLE_CYC(75)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .bus_rst_n(bus_rst_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .stby(stby), .auto_stby(auto_stby), .page_hit(page_hit),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data)
  );

  // array model: word = {C3, page, index}
  always @(posedge clk) begin
    cyc++;
    if (mem_rd_en) begin
      fetches++;
      for (int w = 0; w < 4; w++) mem_rd_data[w*DW +: DW] <= {8'hC3, mem_rd_addr, 2'(w)};
    end
    if (cmd_valid && cmd_ready) begin
      cmds++; last_a = cmd_addr; last_d = cmd_data;
    end
    if (dq_oe) oe_seen = 1;
    if (cyc > 150000 && !done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_cycle(input bit ce_first, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe_lvl);
    @(negedge clk);
    oe_n = oe_lvl; addr = 8'h11;
    if (ce_first) ce_n = 0; else we_n = 0;
    nclk(10);
    addr = a;
    if (ce_first) we_n = 0; else ce_n = 0;
    nclk(10);
    addr = 8'h22; dq_in = d;
    if (ce_first) we_n = 1; else ce_n = 1;
    nclk(10);
    dq_in = 16'hDEAD;
    ce_n = 1; we_n = 1;
    nclk(10);
    oe_n = 1;
    nclk(10);
  endtask

  // {address, fetch expected}
  localparam logic [8:0] RV [8] = '{
    {8'h40, 1'b1}, {8'h41, 1'b0}, {8'h43, 1'b0}, {8'h42, 1'b0},
    {8'h44, 1'b1}, {8'h47, 1'b0}, {8'h40, 1'b1}, {8'hFF, 1'b1}
  };

  initial begin
    int f0, c0;
    nclk(4);
    rst_n = 1;
    nclk(3);
    // reset state
    chk(!dq_oe && stby && !cmd_valid && !page_hit && !auto_stby && !mem_rd_en,
        "R9 reset state", {dq_oe, stby, cmd_valid, page_hit, auto_stby}, 5'b01000);

    // R1/R2 page reads from the vector table
    addr = 0; ce_n = 0; oe_n = 0;
    nclk(12);
    chk(dq_oe == 1, "R1 read drives", dq_oe, 1);
    for (int i = 0; i < 8; i++) begin
      f0 = fetches;
      @(negedge clk); addr = RV[i][8:1]; #1;
      chk(page_hit == !RV[i][0], "R2 immediate hit", page_hit, !RV[i][0]);
      nclk(6);
      chk(dq_out == {8'hC3, RV[i][8:1]} && page_hit, "R1 read data", dq_out, {8'hC3, RV[i][8:1]});
      chk(fetches - f0 == int'(RV[i][0]), "R2 fetch count", fetches - f0, RV[i][0]);
    end

    // R9 output disable and standby
    oe_n = 1; nclk(8);
    chk(!dq_oe && !stby, "R9 output disable", {dq_oe, stby}, 2'b00);
    ce_n = 1; nclk(8);
    chk(!dq_oe && stby, "R9 standby", {dq_oe, stby}, 2'b01);

    // R3/R4 write, chip select first then write strobe
    c0 = cmds;
    wr_cycle(1, 8'h5A, 16'h1234, 1'b1);
    chk(cmds == c0 + 1 && last_a == 8'h5A, "R3 late fall addr", last_a, 8'h5A);
    chk(last_d == 16'h1234, "R4 early rise data", last_d, 16'h1234);
    c0 = cmds;
    wr_cycle(0, 8'hA5, 16'hBEEF, 1'b1);
    chk(cmds == c0 + 1 && last_a == 8'hA5, "R3 late fall addr (we first)", last_a, 8'hA5);
    chk(last_d == 16'hBEEF, "R4 early rise data (ce first up)", last_d, 16'hBEEF);

    // R5 output enable low during write
    c0 = cmds;
    wr_cycle(1, 8'h33, 16'h5555, 1'b0);
    chk(cmds == c0, "R5 rejected write", cmds - c0, 0);

    // R6 pending command holds, second write discarded
    cmd_ready = 0; c0 = cmds;
    wr_cycle(1, 8'h30, 16'h1111, 1'b1);
    chk(cmd_valid && cmd_addr == 8'h30 && cmd_data == 16'h1111, "R6 pending", cmd_addr, 8'h30);
    wr_cycle(0, 8'h31, 16'h2222, 1'b1);
    chk(cmd_valid && cmd_addr == 8'h30 && cmd_data == 16'h1111, "R6 hold over second write", cmd_data, 16'h1111);
    @(negedge clk); cmd_ready = 1; nclk(5);
    chk(cmds == c0 + 1 && last_d == 16'h1111 && !cmd_valid, "R6 one command", cmds - c0, 1);

    // R7 short pulses ignored, long pulse taken
    c0 = cmds;
    @(negedge clk); ce_n = 0; nclk(10);
    @(negedge clk); we_n = 0; @(negedge clk); we_n = 1;
    nclk(15);
    chk(cmds == c0, "R7 we glitch", cmds - c0, 0);
    oe_seen = 0;
    @(negedge clk); oe_n = 0; @(negedge clk); oe_n = 1;
    nclk(15);
    chk(!oe_seen, "R7 oe glitch", oe_seen, 0);
    @(negedge clk); we_n = 0; repeat (3) @(negedge clk); we_n = 1;
    nclk(15);
    chk(cmds == c0 + 1, "R7 long pulse", cmds - c0, 1);
    ce_n = 1; nclk(10);

    // R8 automatic standby
    nclk(90);
    chk(auto_stby == 1, "R8 idle flag", auto_stby, 1);
    @(negedge clk); addr = 8'h45; ce_n = 0; oe_n = 0;
    nclk(10);
    chk(auto_stby == 0 && dq_oe, "R8 wake", auto_stby, 0);
    nclk(90);
    chk(auto_stby && dq_oe && dq_out == 16'hC345, "R8 read held in standby", dq_out, 16'hC345);

    // R10 bus reset
    f0 = fetches;
    @(negedge clk); bus_rst_n = 0; nclk(10);
    chk(!dq_oe && fetches == f0, "R10 quiet in reset", dq_oe, 0);
    @(negedge clk); bus_rst_n = 1; nclk(10);
    chk(fetches == f0 + 1 && dq_out == 16'hC345, "R10 refetch", fetches - f0, 1);
    ce_n = 1; oe_n = 1; nclk(10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule